// File: doc/BRIEF.md
# Interrupt Context Save Sequencer

This block performs the register-saving step of interrupt entry for a processor whose memory port is 16 bits wide. A single-cycle start pulse hands it a 20-bit program counter, a 16-bit flag word, a stack-select bit and both candidate stack pointers. It latches these values and stores a four-byte frame in the memory just below the selected stack pointer. It then reports completion and returns the stack pointer lowered by four, so the pointer's owner can update it.

The number of bus cycles depends on the alignment of the selected pointer. An even pointer allows two full-word stores. An odd pointer forces four single-byte stores, placed so that the resulting memory image is the same in both cases. The byte nearest the old stack top is shared: it holds the four upper flag bits and the four upper program-counter bits. Each store waits on a ready handshake from memory.

Top module: `irq_ctx_saver`

## Requirements
- R1: With `rst_n` sampled low on a rising edge, `mem_we`, `done`, `usp_we` and `isp_we` are all low in the following cycle. The block stays idle after reset until a new start.
- R2: If the selected pointer S is even, exactly two word stores with `mem_be` = 2'b11 occur. The first goes to S-2 with data {S-1 byte, flag[7:0]}. The second goes to S-4 with data pc[15:0].
- R3: If S is odd, exactly four byte stores occur. They go to S-1, S-2, S-3 and S-4, in that order, carrying the S-1 byte, flag[7:0], pc[15:8] and pc[7:0].
- R4: A byte store to an even address uses `mem_be` = 2'b01 with the byte on `mem_wdata[7:0]`. A byte store to an odd address uses 2'b10 with the byte on `mem_wdata[15:8]`. The unused lane is driven to zero.
- R5: The byte stored at S-1 holds flag[15:12] in bits 7:4 and pc[19:16] in bits 3:0.
- R6: While `mem_we` is high and `mem_rdy` is low, the next cycle keeps `mem_we` high with `mem_addr`, `mem_wdata` and `mem_be` unchanged.
- R7: `done` is high for exactly one cycle, the cycle right after the last store is accepted. In that cycle `sp_new` equals S-4.
- R8: `stk_sel` = 1 selects `isp_in` and `stk_sel` = 0 selects `usp_in`. During `done`, only the matching strobe (`isp_we` or `usp_we`) is high. Neither strobe is high outside `done`.
- R9: The frame content and the addresses come from the inputs sampled on the start cycle. Changes to the inputs afterwards have no effect.
- R10: A start that arrives while a save is in progress, including its `done` cycle, is ignored. It neither restarts the frame nor recaptures the inputs.
- R11: Address arithmetic and `sp_new` wrap modulo 2^16. For example, S = 0x0001 gives stores at 0x0000, 0xFFFF, 0xFFFE and 0xFFFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Interrupt accepted, begin a save |
| pc_in | input | 20 | Program counter to save |
| flg_in | input | 16 | Flag word to save |
| stk_sel | input | 1 | 1 selects the interrupt stack pointer, 0 the user stack pointer |
| usp_in | input | 16 | Current user stack pointer |
| isp_in | input | 16 | Current interrupt stack pointer |
| mem_addr | output | 16 | Byte address of the current store |
| mem_wdata | output | 16 | Store data; the low lane is the even byte |
| mem_be | output | 2 | Lane enables; bit 0 is the low lane |
| mem_we | output | 1 | Store request, held until accepted |
| mem_rdy | input | 1 | Memory accepts the store on this edge |
| done | output | 1 | One-cycle completion pulse |
| sp_new | output | 16 | Lowered stack pointer, valid with done |
| usp_we | output | 1 | Load sp_new into the user stack pointer |
| isp_we | output | 1 | Load sp_new into the interrupt stack pointer |

## Verification
The bench tests both pointer parities on both stacks. This would catch a design that picks the wrong bus width or reads the unselected pointer: it would produce the wrong number of stores or store at the wrong place. Pointers close to zero force the address to wrap, and a design that does not wrap would write above the top of memory. Memory wait states check that a design does not advance before `mem_rdy` or change data while stalled. Changing the inputs after start, holding start high through a whole save including its `done` cycle, and resetting in the middle of a frame would expose a design that recaptures or restarts. Such a design would show extra stores, mixed data or a second `done` pulse.

// File: rtl/ctx_save_pkg.sv
// Shared types and constants for the interrupt context save sequencer.
// Assumes a byte-addressed memory with a 16-bit data path.
package ctx_save_pkg;
    typedef enum logic [1:0] {
        SV_IDLE = 2'd0,
        SV_PUSH = 2'd1,
        SV_FIN  = 2'd2
    } save_state_e;

    localparam int FRAME_BYTES = 4;
    localparam int WORD_STEPS  = FRAME_BYTES / 2;
    localparam int BYTE_STEPS  = FRAME_BYTES;
    localparam int STEP_W      = $clog2(BYTE_STEPS);
endpackage

// File: rtl/ctx_frame_packer.sv
// Builds the four saved bytes. Index k is the byte that belongs at S-4+k.
// Assumes PC_W-16 upper program-counter bits share one byte with the top
// flag bits, which fill the rest of that byte.
module ctx_frame_packer #(
    parameter int PC_W  = 20,
    parameter int FLG_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [FLG_W-1:0] flg,
    output logic [3:0][7:0]  frame
);
    localparam int PC_TOP_W    = PC_W - 16;
    localparam int FLG_TOP_LSB = FLG_W - (8 - PC_TOP_W);

    // Place each field into its frame byte.
    always_comb begin
        frame[0] = pc[7:0];
        frame[1] = pc[15:8];
        frame[2] = flg[7:0];
        frame[3] = {flg[FLG_W-1:FLG_TOP_LSB], pc[PC_W-1:16]};
    end
endmodule

// File: rtl/ctx_save_seq.sv
// Control state machine: idle, storing (one step per accepted store), finish.
// Assumes the odd flag is stable for the whole save (it comes from a latched pointer).
module ctx_save_seq
    import ctx_save_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              odd,
    input  logic              rdy,
    output save_state_e       state,
    output logic [STEP_W-1:0] step,
    output logic              capture
);
    logic last;

    // Decide whether the current step is the final store of the frame.
    always_comb begin
        last    = odd ? (step == STEP_W'(BYTE_STEPS - 1)) : (step == STEP_W'(WORD_STEPS - 1));
        capture = (state == SV_IDLE) && start;
    end

    // Advance the state and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SV_IDLE;
            step  <= '0;
        end else begin
            case (state)
                SV_IDLE: begin
                    step <= '0;
                    if (start) state <= SV_PUSH;
                end
                SV_PUSH: begin
                    if (rdy) begin
                        if (last) state <= SV_FIN;
                        else      step  <= step + 1'b1;
                    end
                end
                SV_FIN:  state <= SV_IDLE;
                default: state <= SV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ctx_bus_lane.sv
// Maps a step to the store address, lane data and lane enables.
// An even pointer gives word stores (upper pair first). An odd pointer gives
// byte stores in descending address order.
module ctx_bus_lane
    import ctx_save_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]     sp,
    input  logic              odd,
    input  logic [STEP_W-1:0] step,
    input  logic [3:0][7:0]   frame,
    output logic [AW-1:0]     addr,
    output logic [15:0]       data,
    output logic [1:0]        be
);
    logic [1:0] byte_idx;
    logic [1:0] word_base;
    logic [1:0] lane_on;
    logic [7:0] lane_src [2];

    // Address and index of the frame byte(s) for this step.
    always_comb begin
        byte_idx  = 2'(BYTE_STEPS - 1) - 2'(step);
        word_base = {~step[0], 1'b0};
        if (odd) addr = sp - AW'(FRAME_BYTES) + AW'(byte_idx);
        else     addr = sp - AW'(FRAME_BYTES) + AW'(word_base);
    end

    for (genvar l = 0; l < 2; l++) begin : g_lane
        // Select and enable the byte that travels on lane l.
        always_comb begin
            lane_src[l] = odd ? frame[byte_idx] : frame[word_base + 2'(l)];
            lane_on[l]  = !odd || (addr[0] == l[0]);
            data[8*l +: 8] = lane_on[l] ? lane_src[l] : 8'h00;
        end
    end

    assign be = lane_on;
endmodule

// File: rtl/irq_ctx_saver.sv
// Top of the interrupt context save sequencer. Latches the context on start,
// stores the four-byte frame below the selected stack pointer, then pulses
// done together with the lowered pointer and a strobe for its owner.
module irq_ctx_saver
    import ctx_save_pkg::*;
#(
    parameter int PC_W  = 20,
    parameter int FLG_W = 16,
    parameter int SP_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [FLG_W-1:0] flg_in,
    input  logic             stk_sel,
    input  logic [SP_W-1:0]  usp_in,
    input  logic [SP_W-1:0]  isp_in,
    output logic [SP_W-1:0]  mem_addr,
    output logic [15:0]      mem_wdata,
    output logic [1:0]       mem_be,
    output logic             mem_we,
    input  logic             mem_rdy,
    output logic             done,
    output logic [SP_W-1:0]  sp_new,
    output logic             usp_we,
    output logic             isp_we
);
    logic [PC_W-1:0]   pc_q;
    logic [FLG_W-1:0]  flg_q;
    logic [SP_W-1:0]   sp_q;
    logic              sel_q;
    logic              capture;
    save_state_e       state;
    logic [STEP_W-1:0] step;
    logic [3:0][7:0]   frame;

    // Latch the context only when a save is accepted from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            flg_q <= '0;
            sp_q  <= '0;
            sel_q <= 1'b0;
        end else if (capture) begin
            pc_q  <= pc_in;
            flg_q <= flg_in;
            sp_q  <= stk_sel ? isp_in : usp_in;
            sel_q <= stk_sel;
        end
    end

    ctx_save_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .odd     (sp_q[0]),
        .rdy     (mem_rdy),
        .state   (state),
        .step    (step),
        .capture (capture)
    );

    ctx_frame_packer #(.PC_W(PC_W), .FLG_W(FLG_W)) u_pack (
        .pc    (pc_q),
        .flg   (flg_q),
        .frame (frame)
    );

    ctx_bus_lane #(.AW(SP_W)) u_lane (
        .sp    (sp_q),
        .odd   (sp_q[0]),
        .step  (step),
        .frame (frame),
        .addr  (mem_addr),
        .data  (mem_wdata),
        .be    (mem_be)
    );

    // Drive the store strobe, the completion pulse and the pointer write-back.
    always_comb begin
        mem_we = (state == SV_PUSH);
        done   = (state == SV_FIN);
        sp_new = sp_q - SP_W'(FRAME_BYTES);
        usp_we = done && !sel_q;
        isp_we = done && sel_q;
    end
endmodule

// File: rtl/irq_ctx_saver_chk.sv
// Protocol checker for irq_ctx_saver, bound to every instance of it.
module irq_ctx_saver_chk #(
    parameter int SP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [SP_W-1:0] mem_addr,
    input logic [15:0]     mem_wdata,
    input logic [1:0]      mem_be,
    input logic            mem_we,
    input logic            mem_rdy,
    input logic            done,
    input logic            usp_we,
    input logic            isp_we
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_we && !done && !usp_we && !isp_we));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_rdy) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

    // R8
    strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({usp_we, isp_we}));

    // R8
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!usp_we && !isp_we));

    // R4
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be != 2'b11) |-> ($onehot(mem_be) && (mem_be[1] == mem_addr[0])));

    // R2
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be == 2'b11) |-> !mem_addr[0]);
endmodule

bind irq_ctx_saver irq_ctx_saver_chk #(.SP_W(SP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .mem_we    (mem_we),
    .mem_rdy   (mem_rdy),
    .done      (done),
    .usp_we    (usp_we),
    .isp_we    (isp_we)
);

// File: tb/sim_irq_ctx_saver.sv
module sim_irq_ctx_saver;
    localparam int CLK_PERIOD = 10;

    // pc, flags, select, user sp, interrupt sp, wait states
    localparam logic [72:0] VECS [6] = '{
        {20'hA1234, 16'hC0F5, 1'b0, 16'h1000, 16'h2000, 4'd0},
        {20'h5ABCD, 16'h3E81, 1'b1, 16'h1000, 16'h2FF1, 4'd0},
        {20'hF00FF, 16'h9001, 1'b0, 16'h0777, 16'h4444, 4'd2},
        {20'h00010, 16'hFFFF, 1'b1, 16'h0003, 16'h0000, 4'd1},
        {20'h7FFFE, 16'h0000, 1'b0, 16'h0001, 16'h8000, 4'd3},
        {20'h12345, 16'hA5A5, 1'b1, 16'hFFFF, 16'h8002, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n, start, stk_sel, mem_rdy;
    logic [19:0] pc_in;
    logic [15:0] flg_in, usp_in, isp_in;
    logic [15:0] mem_addr, mem_wdata, sp_new;
    logic [1:0]  mem_be;
    logic        mem_we, done, usp_we, isp_we;

    int n_chk = 0, n_bad = 0, nlog = 0, done_cnt = 0;
    int wait_cfg = 0, wait_cnt = 0, cyc = 0, acc_cyc = 0, done_cyc = 0;
    bit finished = 1'b0;
    logic [15:0] la [8];
    logic [15:0] ld [8];
    logic [1:0]  lb [8];
    logic [15:0] got_sp, ha, hd;
    logic [1:0]  hb;
    logic        got_u, got_i, hv = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctx_saver u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in), .flg_in(flg_in),
        .stk_sel(stk_sel), .usp_in(usp_in), .isp_in(isp_in), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_we(mem_we), .mem_rdy(mem_rdy),
        .done(done), .sp_new(sp_new), .usp_we(usp_we), .isp_we(isp_we)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Memory model with wait states, stall-hold check and done monitor.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rdy = 1'b0;
            hv = 1'b0;
        end else begin
            if (hv) begin
                chk("R6 we held", {31'b0, mem_we}, 1);
                chk("R6 addr held", {16'b0, mem_addr}, {16'b0, ha});
                chk("R6 data held", {16'b0, mem_wdata}, {16'b0, hd});
                chk("R6 be held", {30'b0, mem_be}, {30'b0, hb});
            end
            hv = 1'b0;
            if (mem_we) begin
                if (wait_cnt == 0) begin
                    if (nlog < 8) begin
                        la[nlog] = mem_addr;
                        ld[nlog] = mem_wdata;
                        lb[nlog] = mem_be;
                    end
                    nlog++;
                    acc_cyc = cyc;
                    mem_rdy = 1'b1;
                    wait_cnt = wait_cfg;
                end else begin
                    mem_rdy = 1'b0;
                    wait_cnt--;
                    hv = 1'b1;
                    ha = mem_addr;
                    hd = mem_wdata;
                    hb = mem_be;
                end
            end else begin
                mem_rdy = 1'b0;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
                got_sp = sp_new;
                got_u = usp_we;
                got_i = isp_we;
            end
        end
    end

    task automatic check_frame(input logic [19:0] pc, input logic [15:0] flg, input logic sel,
                               input logic [15:0] usp, input logic [15:0] isp);
        logic [15:0] s, a;
        logic [7:0]  b [4];
        logic [15:0] ea [4];
        logic [15:0] ed [4];
        logic [1:0]  eb [4];
        int n;
        string base;
        s = sel ? isp : usp;
        b[0] = pc[7:0];
        b[1] = pc[15:8];
        b[2] = flg[7:0];
        b[3] = {flg[15:12], pc[19:16]};
        if (!s[0]) begin
            base = "R2";
            n = 2;
            ea[0] = s - 16'd2; ed[0] = {b[3], b[2]}; eb[0] = 2'b11;
            ea[1] = s - 16'd4; ed[1] = {b[1], b[0]}; eb[1] = 2'b11;
        end else begin
            base = "R3";
            n = 4;
            for (int k = 0; k < 4; k++) begin
                a = s - 16'd1 - 16'(k);
                ea[k] = a;
                eb[k] = a[0] ? 2'b10 : 2'b01;
                ed[k] = a[0] ? {b[3-k], 8'h00} : {8'h00, b[3-k]};
            end
        end
        chk({base, " store count"}, nlog, n);
        for (int k = 0; k < n && k < nlog; k++) begin
            chk((s < 16'd4) ? "R11 wrapped addr" : {base, " addr"}, {16'b0, la[k]}, {16'b0, ea[k]});
            chk((n == 4) ? "R4 lane enable" : "R2 word enable", {30'b0, lb[k]}, {30'b0, eb[k]});
            chk((k == 0) ? "R5 shared byte" : "R9 captured data", {16'b0, ld[k]}, {16'b0, ed[k]});
        end
        chk("R7 done count", done_cnt, 1);
        chk("R7 done timing", done_cyc, acc_cyc + 1);
        chk((s < 16'd4) ? "R11 sp_new wrap" : "R7 sp_new", {16'b0, got_sp}, {16'b0, s - 16'd4});
        chk("R8 usp_we", {31'b0, got_u}, {31'b0, !sel});
        chk("R8 isp_we", {31'b0, got_i}, {31'b0, sel});
    endtask

    task automatic run_vec(input logic [72:0] v);
        logic [19:0] pc;
        logic [15:0] flg, usp, isp;
        logic sel;
        pc = v[72:53]; flg = v[52:37]; sel = v[36]; usp = v[35:20]; isp = v[19:4];
        @(negedge clk);
        nlog = 0; done_cnt = 0;
        wait_cfg = int'(v[3:0]); wait_cnt = int'(v[3:0]);
        pc_in = pc; flg_in = flg; stk_sel = sel; usp_in = usp; isp_in = isp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: scramble every input once the start has been taken
        pc_in = ~pc; flg_in = ~flg; stk_sel = ~sel;
        usp_in = usp ^ 16'h0101; isp_in = isp ^ 16'h0101;
        for (int i = 0; i < 80 && done_cnt == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check_frame(pc, flg, sel, usp, isp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; stk_sel = 1'b0;
        pc_in = '0; flg_in = '0; usp_in = '0; isp_in = '0;
        repeat (3) @(negedge clk);
        chk("R1 we in reset", {31'b0, mem_we}, 0);
        chk("R1 done in reset", {31'b0, done}, 0);
        chk("R1 strobes in reset", {30'b0, usp_we, isp_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {31'b0, mem_we}, 0);

        for (int i = 0; i < 6; i++) run_vec(VECS[i]);

        // R10: start held high through a whole save, inputs changing meanwhile
        @(negedge clk);
        nlog = 0; done_cnt = 0; wait_cfg = 1; wait_cnt = 1;
        pc_in = 20'h3C3C3; flg_in = 16'h6B17; stk_sel = 1'b0;
        usp_in = 16'h3005; isp_in = 16'h0200;
        start = 1'b1;
        @(negedge clk);
        pc_in = 20'h0BEEF; flg_in = 16'h1111; usp_in = 16'h4000; stk_sel = 1'b1;
        for (int i = 0; i < 80 && done_cnt == 0; i++) @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check_frame(20'h3C3C3, 16'h6B17, 1'b0, 16'h3005, 16'h0200);
        chk("R10 no second save", nlog, 4);

        // R1: reset in the middle of a frame
        @(negedge clk);
        nlog = 0; done_cnt = 0; wait_cfg = 5; wait_cnt = 5;
        usp_in = 16'h0100; stk_sel = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset aborts store", {31'b0, mem_we}, 0);
        chk("R1 reset no done", {31'b0, done}, 0);
        rst_n = 1'b1;
        wait_cnt = 0;
        repeat (4) @(negedge clk);
        chk("R1 stays idle", {31'b0, mem_we}, 0);
        chk("R1 no done after abort", done_cnt, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule